// File: doc/BRIEF.md
# Cascadable Presettable Synchronous Binary Counter

This block is a binary up-counter assembled from identical 4-bit stages. All of its state bits are clocked by one rising edge, so every output bit changes in the same cycle. The block has four controls:

- An active-low clear empties the counter at once, without waiting for the clock.
- An active-low load presets the counter from a parallel data word on the next edge.
- A parallel count enable is shared by every stage.
- A chain enable admits the carry.

Inside the block, each stage passes its terminal-count signal to the chain enable of the stage above it. The stage count is a parameter, and the whole chain behaves as one wide counter.

The terminal-count output is combinational. It goes high while every count bit is one and the chain enable is high. A further instance of the block can therefore be hung on it, with no extra gating.

Top module: `cascade_counter`

## Requirements
- R1: While `clear_n` is low, `q` is all zeros. It goes to zero as soon as `clear_n` falls, without a clock edge, whatever `load_n`, `din`, `cnt_en` and `carry_en` are doing.
- R2: When `clear_n` is high and `load_n` is low at a rising edge, `q` takes the value of `din`, whatever the levels of `cnt_en` and `carry_en`.
- R3: When `clear_n` and `load_n` are high and both `cnt_en` and `carry_en` are high at a rising edge, `q` becomes `q + 1` modulo 2^(4·STAGES). All ones wraps to zero.
- R4: When `clear_n` and `load_n` are high and either `cnt_en` or `carry_en` is low at a rising edge, `q` keeps its value.
- R5: `carry_out` is high exactly when every bit of `q` is one and `carry_en` is high. It follows `carry_en` combinationally, with no clock edge needed.
- R6: Stage k drives bits [4k+3:4k] of `q`, and stage 0 is least significant. A stage advances only when every stage below it is all ones, so for example 0x0F counts to 0x10.
- R7: Changes on `load_n`, `din`, `cnt_en` or `carry_en` between clock edges have no effect on `q`. Only their levels at the rising edge matter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared rising-edge clock |
| clear_n | input | 1 | Asynchronous clear, active low |
| load_n | input | 1 | Synchronous parallel preset, active low |
| din | input | 4·STAGES | Preset data word |
| cnt_en | input | 1 | Parallel count enable, shared by all stages |
| carry_en | input | 1 | Chain enable into stage 0; also gates `carry_out` |
| q | output | 4·STAGES | Count value |
| carry_out | output | 1 | Terminal count, for the next cascaded block |

## Verification
The bench presets every 8-bit value, with random enable levels, then counts one step, holds with each enable dropped in turn, and compares the result with arithmetic predictions. That sweep catches several faults:

- A load that obeys the enables shows up in the preset check.
- A missing wrap from 0xFF shows up in the count step.
- A broken stage link shows up at 0x0F, which would not become 0x10.

Further checks target specific faults:

- **Ungated terminal count.** A `carry_out` that ignores `carry_en`, or that is registered, is caught by toggling `carry_en` between edges at 0xFF, and by probing values that are only partly all ones.
- **Synchronous clear.** Clear is dropped in the middle of a cycle, and the output must already be zero before the next edge.
- **Mid-cycle control glitches.** Load is pulsed between edges, and a design that latches it at that moment would show the glitched value.
- **Everything together.** A long random run against a behavioural model exercises all the controls in combination.

// File: rtl/cnt_pkg.sv
// Shared types for the cascadable counter: the per-stage operation code
// and the function that picks it from the synchronous controls.
package cnt_pkg;

    // Operation a stage performs at the next rising edge.
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_INC  = 2'd1,
        OP_LOAD = 2'd2
    } stage_op_e;

    // Priority among the synchronous controls: load, then count, then hold.
    function automatic stage_op_e pick_op(input logic load_n,
                                          input logic par_en,
                                          input logic chain_en);
        stage_op_e op;
        if (!load_n)
            op = OP_LOAD;
        else if (par_en && chain_en)
            op = OP_INC;
        else
            op = OP_HOLD;
        return op;
    endfunction

endpackage

// File: rtl/stage_ctrl.sv
// stage_ctrl: decodes the synchronous controls of one stage into an
// operation code. Purely combinational. Assumes the asynchronous clear
// is handled by the register itself.
module stage_ctrl
    import cnt_pkg::*;
(
    input  logic      load_n,
    input  logic      par_en,
    input  logic      chain_en,
    output stage_op_e op
);

    // Select the operation for the coming edge.
    always_comb begin
        op = pick_op(load_n, par_en, chain_en);
    end

endmodule

// File: rtl/stage_carry.sv
// stage_carry: terminal-count detect for one stage. The output is high
// while the stage is all ones and its chain enable is high. Combinational,
// so the carry ripples through the chain within one cycle.
module stage_carry #(
    parameter int W = 4
) (
    input  logic [W-1:0] q,
    input  logic         chain_en,
    output logic         carry
);

    logic full;

    // Detect the all-ones value of this stage.
    always_comb begin
        full = &q;
    end

    // Gate the terminal count with the incoming chain enable only.
    always_comb begin
        carry = full && chain_en;
    end

endmodule

// File: rtl/count_stage.sv
// count_stage: one presettable binary counter slice. Clears
// asynchronously on clear_n low, otherwise loads, increments or holds on
// the rising edge of clk. Assumes all stages share clk and par_en.
module count_stage
    import cnt_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         clear_n,
    input  logic         load_n,
    input  logic [W-1:0] din,
    input  logic         par_en,
    input  logic         chain_en,
    output logic [W-1:0] q,
    output logic         carry
);

    stage_op_e    op;
    logic [W-1:0] cnt_r;
    logic [W-1:0] cnt_nx;

    stage_ctrl u_ctrl (
        .load_n   (load_n),
        .par_en   (par_en),
        .chain_en (chain_en),
        .op       (op)
    );

    // Next value of the slice for each operation.
    always_comb begin
        unique case (op)
            OP_LOAD: cnt_nx = din;
            OP_INC:  cnt_nx = cnt_r + W'(1);
            default: cnt_nx = cnt_r;
        endcase
    end

    // State register with asynchronous clear.
    always_ff @(posedge clk or negedge clear_n) begin
        if (!clear_n)
            cnt_r <= '0;
        else
            cnt_r <= cnt_nx;
    end

    always_comb begin
        q = cnt_r;
    end

    stage_carry #(.W(W)) u_carry (
        .q        (cnt_r),
        .chain_en (chain_en),
        .carry    (carry)
    );

endmodule

// File: rtl/cascade_counter.sv
// cascade_counter: STAGES count_stage slices chained so that each stage's
// terminal count drives the chain enable of the stage above it. Behaves
// as one STAGES*STAGE_W bit counter; carry_out is the last stage's carry.
// Assumes a single clock domain; clear_n is asynchronous.
module cascade_counter #(
    parameter int STAGES  = 2,
    parameter int STAGE_W = 4,
    localparam int TOTAL_W = STAGES * STAGE_W
) (
    input  logic               clk,
    input  logic               clear_n,
    input  logic               load_n,
    input  logic [TOTAL_W-1:0] din,
    input  logic               cnt_en,
    input  logic               carry_en,
    output logic [TOTAL_W-1:0] q,
    output logic               carry_out
);

    logic [STAGES:0] chain;

    // Chain enable of stage 0 is the external enable.
    always_comb begin
        chain[0] = carry_en;
    end

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        count_stage #(.W(STAGE_W)) u_stage (
            .clk      (clk),
            .clear_n  (clear_n),
            .load_n   (load_n),
            .din      (din[k*STAGE_W +: STAGE_W]),
            .par_en   (cnt_en),
            .chain_en (chain[k]),
            .q        (q[k*STAGE_W +: STAGE_W]),
            .carry    (chain[k+1])
        );
    end

    // Terminal count of the whole chain.
    always_comb begin
        carry_out = chain[STAGES];
    end

endmodule

// File: rtl/counter_checker.sv
// counter_checker: assertions on the ports of cascade_counter, bound in.
module counter_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         clear_n,
    input logic         load_n,
    input logic [W-1:0] din,
    input logic         cnt_en,
    input logic         carry_en,
    input logic [W-1:0] q,
    input logic         carry_out
);

    // R1: while clear is held low, the count reads zero at every edge.
    always @(posedge clk) begin
        if (!clear_n) begin
            a_clear_zero_r1: assert (q == '0);
        end
    end

    p_load_copies_r2: assert property (@(posedge clk) disable iff (!clear_n)
        !load_n |=> q == $past(din));

    p_count_step_r3: assert property (@(posedge clk) disable iff (!clear_n)
        (load_n && cnt_en && carry_en) |=> q == W'($past(q) + 1'b1));

    p_hold_r4: assert property (@(posedge clk) disable iff (!clear_n)
        (load_n && !(cnt_en && carry_en)) |=> $stable(q));

    p_carry_gate_r5: assert property (@(posedge clk) disable iff (!clear_n)
        carry_out == ((&q) && carry_en));

endmodule

bind cascade_counter counter_checker #(.W(TOTAL_W)) u_chk (
    .clk       (clk),
    .clear_n   (clear_n),
    .load_n    (load_n),
    .din       (din),
    .cnt_en    (cnt_en),
    .carry_en  (carry_en),
    .q         (q),
    .carry_out (carry_out)
);

// File: tb/tb_cascade_counter.sv
module tb_cascade_counter;

    localparam int STAGES     = 2;
    localparam int SW         = 4;
    localparam int W          = STAGES * SW;
    localparam int CLK_PERIOD = 10;
    localparam int MAXV       = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         clear_n;
    logic         load_n;
    logic [W-1:0] din;
    logic         cnt_en;
    logic         carry_en;
    logic [W-1:0] q;
    logic         carry_out;

    int total = 0;
    int bad   = 0;
    int exp_q = 0;

    cascade_counter #(.STAGES(STAGES), .STAGE_W(SW)) dut (
        .clk       (clk),
        .clear_n   (clear_n),
        .load_n    (load_n),
        .din       (din),
        .cnt_en    (cnt_en),
        .carry_en  (carry_en),
        .q         (q),
        .carry_out (carry_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, expv);
        end
    endtask

    // One clock edge: predict from the levels at the edge, then compare.
    task automatic tick(input string req);
        int nx;
        if (!clear_n)                  nx = 0;
        else if (!load_n)              nx = int'(din);
        else if (cnt_en && carry_en)   nx = (exp_q + 1) & MAXV;
        else                           nx = exp_q;
        @(posedge clk);
        #1;
        exp_q = nx;
        chk(req, int'(q), exp_q);
        chk("R5 carry", int'(carry_out), int'(exp_q == MAXV && carry_en));
    endtask

    task automatic preset(input int v);
        load_n = 1'b0; din = W'(v);
        tick("R2 preset");
        load_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        total++; bad++;
        $display("FAIL watchdog R1 act=%0d exp=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        clear_n = 1'b0; load_n = 1'b1; din = '0; cnt_en = 1'b1; carry_en = 1'b1;
        tick("R1 reset");
        tick("R1 reset held");
        clear_n = 1'b1;

        // Sweep: preset every value with random enables, then count and hold.
        for (int v = 0; v <= MAXV; v++) begin
            cnt_en = 1'($urandom); carry_en = 1'($urandom);
            load_n = 1'b0; din = W'(v);
            tick("R2 load overrides enables");
            load_n = 1'b1; cnt_en = 1'b1; carry_en = 1'b1;
            tick("R3 count step");
            cnt_en = 1'b0;
            tick("R4 hold par enable low");
            cnt_en = 1'b1; carry_en = 1'b0;
            tick("R4 hold chain enable low");
        end

        // Stage link and wrap.
        cnt_en = 1'b1; carry_en = 1'b1;
        preset(8'h0F);
        tick("R6 low stage carries into high stage");
        chk("R6 value 0x10", int'(q), 8'h10);
        preset(8'hFF);
        tick("R3 wrap to zero");
        chk("R3 wrap value", int'(q), 0);

        // Combinational gating of the terminal count.
        cnt_en = 1'b0; carry_en = 1'b0;
        preset(8'hFF);
        #1 chk("R5 gated low at all ones", int'(carry_out), 0);
        carry_en = 1'b1;
        #1 chk("R5 follows chain enable between edges", int'(carry_out), 1);
        carry_en = 1'b0;
        #1 chk("R5 drops between edges", int'(carry_out), 0);
        carry_en = 1'b1;
        preset(8'hF0);
        chk("R5 partial ones no carry", int'(carry_out), 0);
        preset(8'h0F);
        chk("R5 low stage only no carry", int'(carry_out), 0);

        // Controls wiggled between edges have no effect.
        cnt_en = 1'b0;
        preset(8'h35);
        #1 load_n = 1'b0; din = 8'hAA; cnt_en = 1'b1;
        #2 load_n = 1'b1; din = 8'h00; cnt_en = 1'b0;
        #1 chk("R7 no change between edges", int'(q), 8'h35);
        tick("R7 hold after glitch");

        // Clear dropped in the middle of a cycle.
        cnt_en = 1'b1;
        preset(8'h5C);
        #2 clear_n = 1'b0;
        #1 chk("R1 async clear mid cycle", int'(q), 0);
        load_n = 1'b0; din = 8'h77;
        tick("R1 clear beats load");
        clear_n = 1'b1; load_n = 1'b1;
        tick("R3 count after clear");

        // Random run against the model.
        for (int i = 0; i < 4000; i++) begin
            clear_n  = ($urandom % 64) != 0;
            load_n   = ($urandom % 8) != 0;
            din      = W'($urandom);
            cnt_en   = ($urandom % 4) != 0;
            carry_en = ($urandom % 4) != 0;
            if (!clear_n)                 tick("R1 random");
            else if (!load_n)             tick("R2 random");
            else if (cnt_en && carry_en)  tick("R3 random");
            else                          tick("R4 random");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule